// File: doc/BRIEF.md
# Programmable-Logic Configuration Sequencer

This block is the phase controller of a programmable device's configuration path. After power is good it waits out a power-on delay. It then holds the device in an initialization phase until the active-low program and clear pins are both released. It stays in configuration until a bitstream loader reports that loading is finished. It then runs a short start-up phase and ends in user operation.

The status outputs follow the phase. `done` and the busy pair can steer external logic such as memory enables or bus isolation. The I/O tri-state and weak pull-down enables keep user pins quiet until it is safe to release them. The mode-select value is captured when configuration starts and held for the loader and the rest of the chip.

The two pins do not act the same way in every phase. Either pin aborts a configuration in progress. Once start-up has begun, only the program pin can force a new configuration, and the clear pin is ignored. All inputs are sampled on the configuration clock. Shifting the bitstream and monitoring the supply are done elsewhere.

Top module: `cfgseq_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, the outputs show power-on reset: `done`=0, `busy_hi`=0, `busy_lo_n`=1, `io_tristate`=1, `pulldn_en`=1, `mode_latched`=0.
- R2: Initialization is entered (`busy_hi` rises) on the POR_CYCLES-th consecutive clock edge at which `power_ok` is high. A cycle with `power_ok` low restarts the count from zero.
- R3: Initialization moves to configuration only at a clock edge where both `prog_n` and `clr_n` are 1. While either pin is 0 the machine stays in initialization and `mode_latched` does not change.
- R4: In configuration, a 0 on `prog_n` or on `clr_n` returns the machine to initialization at the next edge. This takes priority over `load_done`. Otherwise `load_done`=1 enters start-up.
- R5: `done` is 0 in power-on reset, initialization and configuration, and 1 in start-up and operating.
- R6: `busy_hi`=1 and `busy_lo_n`=0 exactly in initialization and configuration. Both are at their inactive levels (0 and 1) in every other phase.
- R7: `pulldn_en`=1 and `io_tristate`=1 in power-on reset, initialization and configuration. `pulldn_en`=0 in start-up and operating.
- R8: Start-up lasts exactly STARTUP_CYCLES clock cycles and then becomes operating. A STARTUP_CYCLES value below 3 is treated as 3.
- R9: In start-up and operating, `clr_n` has no effect. `prog_n`=0 at an edge returns the machine to initialization.
- R10: `io_tristate` falls to 0 on the second cycle of operating and stays 0 for as long as operating lasts. It is 1 in every other cycle.
- R11: `mode_latched` takes the value of `mode_sel` at the edge that leaves initialization for configuration and holds it at all other edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high reset (power-on reset request) |
| power_ok | input | 1 | Supply-good indication |
| prog_n | input | 1 | Active-low program request |
| clr_n | input | 1 | Active-low configuration clear |
| mode_sel | input | MODE_W | Configuration mode select |
| load_done | input | 1 | Bitstream loader reports loading finished |
| done | output | 1 | Configuration complete |
| busy_hi | output | 1 | High while initializing or configuring |
| busy_lo_n | output | 1 | Low while initializing or configuring |
| io_tristate | output | 1 | Global tri-state enable for user I/O |
| pulldn_en | output | 1 | Weak pull-down enable |
| mode_latched | output | MODE_W | Mode value captured at configuration start |

## Verification
The bench builds the block with POR_CYCLES=6, so the power-on wait, including a restart caused by a dropout, ends within a few cycles. It also sets STARTUP_CYCLES=4, one above the minimum, so a start-up counter that stops at three cycles is caught. MODE_W=3 lets each abort and each re-entry to configuration latch a distinct mode value. That makes an abort visible at the ports even though initialization and configuration drive the same status levels.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

    typedef enum logic [2:0] {
        PH_POR     = 3'd0,
        PH_INIT    = 3'd1,
        PH_CONFIG  = 3'd2,
        PH_STARTUP = 3'd3,
        PH_RUN     = 3'd4
    } phase_t;

    // Control pins seen by the phase controller
    typedef struct packed {
        logic prog_n;
        logic clr_n;
        logic load_done;
    } seq_in_t;

    // Status levels decoded from the phase
    typedef struct packed {
        logic done;
        logic busy_hi;
        logic busy_lo_n;
        logic pulldn;
    } pin_levels_t;

    localparam int MIN_STARTUP = 3;

    function automatic int startup_len(input int requested);
        return (requested < MIN_STARTUP) ? MIN_STARTUP : requested;
    endfunction

    function automatic logic is_configuring(input phase_t p);
        return (p == PH_INIT) || (p == PH_CONFIG);
    endfunction

    function automatic logic is_user_side(input phase_t p);
        return (p == PH_STARTUP) || (p == PH_RUN);
    endfunction

    function automatic logic pins_released(input seq_in_t s);
        return s.prog_n & s.clr_n;
    endfunction

    function automatic pin_levels_t levels_for(input phase_t p);
        pin_levels_t l;
        l.done      = is_user_side(p);
        l.busy_hi   = is_configuring(p);
        l.busy_lo_n = ~is_configuring(p);
        l.pulldn    = ~is_user_side(p);
        return l;
    endfunction

endpackage

// File: rtl/cfgseq_delay_counter.sv
module cfgseq_delay_counter #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic enable,
    output logic expired
);
    localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    assign expired = enable && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (enable) begin
            cnt_q <= expired ? '0 : cnt_q + 1'b1;
        end
    end

    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) < LIMIT) else $error("AST_COUNT_IN_RANGE"); // R8

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt_q == '0)) else $error("AST_CLEAR_ZEROES"); // R2

endmodule

// File: rtl/cfgseq_mode_latch.sv
module cfgseq_mode_latch #(
    parameter int MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [MODE_W-1:0] mode_in,
    output logic [MODE_W-1:0] mode_out
);
    logic [MODE_W-1:0] mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (capture) begin
            mode_q <= mode_in;
        end
    end

    assign mode_out = mode_q;

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(mode_q)) else $error("AST_MODE_HOLD"); // R11

    AST_MODE_TAKEN: assert property (@(posedge clk) disable iff (rst)
        capture |=> (mode_q == $past(mode_in))) else $error("AST_MODE_TAKEN"); // R11

endmodule

// File: rtl/cfgseq_phase_ctrl.sv
module cfgseq_phase_ctrl
    import cfgseq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  seq_in_t pins,
    input  logic    por_expired,
    input  logic    startup_expired,
    output phase_t  phase,
    output logic    capture_mode
);
    phase_t phase_q;
    phase_t phase_d;

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_POR: begin
                if (por_expired) phase_d = PH_INIT;
            end
            PH_INIT: begin
                if (pins_released(pins)) phase_d = PH_CONFIG;
            end
            PH_CONFIG: begin
                if (!pins_released(pins)) phase_d = PH_INIT;
                else if (pins.load_done)  phase_d = PH_STARTUP;
            end
            PH_STARTUP: begin
                if (!pins.prog_n)         phase_d = PH_INIT;
                else if (startup_expired) phase_d = PH_RUN;
            end
            PH_RUN: begin
                if (!pins.prog_n) phase_d = PH_INIT;
            end
            default: phase_d = PH_POR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_POR;
        else     phase_q <= phase_d;
    end

    assign phase        = phase_q;
    assign capture_mode = (phase_q == PH_INIT) && pins_released(pins);

    AST_ENTRY_NEEDS_PINS: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_INIT && !(pins.prog_n && pins.clr_n)) |=> (phase_q == PH_INIT))
        else $error("AST_ENTRY_NEEDS_PINS"); // R3

    AST_ABORT_TO_INIT: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_CONFIG && (!pins.prog_n || !pins.clr_n)) |=> (phase_q == PH_INIT))
        else $error("AST_ABORT_TO_INIT"); // R4

    AST_PROG_RECONFIG: assert property (@(posedge clk) disable iff (rst)
        ((phase_q == PH_STARTUP || phase_q == PH_RUN) && !pins.prog_n) |=> (phase_q == PH_INIT))
        else $error("AST_PROG_RECONFIG"); // R9

    AST_CLEAR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_RUN && pins.prog_n) |=> (phase_q == PH_RUN))
        else $error("AST_CLEAR_IGNORED"); // R9

endmodule

// File: rtl/cfgseq_top.sv
module cfgseq_top
    import cfgseq_pkg::*;
#(
    parameter int MODE_W         = 3,
    parameter int POR_CYCLES     = 1000,
    parameter int STARTUP_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              power_ok,
    input  logic              prog_n,
    input  logic              clr_n,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              load_done,
    output logic              done,
    output logic              busy_hi,
    output logic              busy_lo_n,
    output logic              io_tristate,
    output logic              pulldn_en,
    output logic [MODE_W-1:0] mode_latched
);
    localparam int SU_LEN  = startup_len(STARTUP_CYCLES);
    localparam int POR_LEN = (POR_CYCLES < 1) ? 1 : POR_CYCLES;

    seq_in_t     pins_s;
    phase_t      phase;
    pin_levels_t lv;
    logic        capture_mode;
    logic        por_en, por_expired;
    logic        su_en, su_expired;
    logic        run_seen_q;

    assign pins_s = '{prog_n: prog_n, clr_n: clr_n, load_done: load_done};

    assign por_en = (phase == PH_POR) && power_ok;
    assign su_en  = (phase == PH_STARTUP);

    cfgseq_delay_counter #(.LIMIT(POR_LEN)) i_por_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (!por_en),
        .enable  (por_en),
        .expired (por_expired)
    );

    cfgseq_delay_counter #(.LIMIT(SU_LEN)) i_startup_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (!su_en),
        .enable  (su_en),
        .expired (su_expired)
    );

    cfgseq_phase_ctrl i_ctrl (
        .clk             (clk),
        .rst             (rst),
        .pins            (pins_s),
        .por_expired     (por_expired),
        .startup_expired (su_expired),
        .phase           (phase),
        .capture_mode    (capture_mode)
    );

    cfgseq_mode_latch #(.MODE_W(MODE_W)) i_mode (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture_mode),
        .mode_in  (mode_sel),
        .mode_out (mode_latched)
    );

    // Remembers that the previous cycle was already operating
    always_ff @(posedge clk) begin
        if (rst) run_seen_q <= 1'b0;
        else     run_seen_q <= (phase == PH_RUN);
    end

    assign lv          = levels_for(phase);
    assign done        = lv.done;
    assign busy_hi     = lv.busy_hi;
    assign busy_lo_n   = lv.busy_lo_n;
    assign pulldn_en   = lv.pulldn;
    assign io_tristate = !((phase == PH_RUN) && run_seen_q);

    AST_TRISTATE_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst)
        !done |-> io_tristate) else $error("AST_TRISTATE_UNTIL_DONE"); // R7

    AST_RELEASE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(io_tristate) |-> (done && $past(done))) else $error("AST_RELEASE_AFTER_DONE"); // R10

    AST_BUSY_EXCLUDES_DONE: assert property (@(posedge clk) disable iff (rst)
        busy_hi |-> (!done && !busy_lo_n)) else $error("AST_BUSY_EXCLUDES_DONE"); // R6

    AST_POR_ONLY_WITH_POWER: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_POR) && !power_ok) |=> (phase == PH_POR)) else $error("AST_POR_ONLY_WITH_POWER"); // R2

endmodule

// File: tb/test_cfgseq_top.sv
module test_cfgseq_top;
    localparam int MW   = 3;
    localparam int PORC = 6;
    localparam int SUC  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic power_ok = 1'b0, prog_n = 1'b1, clr_n = 1'b1, load_done = 1'b0;
    logic [MW-1:0] mode_sel = '0;
    logic done, busy_hi, busy_lo_n, io_tristate, pulldn_en;
    logic [MW-1:0] mode_latched;

    int checks = 0;
    int errors = 0;

    // Reference model state: 0 por, 1 init, 2 config, 3 startup, 4 run
    int       m_st = 0, m_pc = 0, m_sc = 0;
    logic [MW-1:0] m_mode = '0;
    bit       m_runq = 1'b0;

    always #5 clk = ~clk;

    cfgseq_top #(.MODE_W(MW), .POR_CYCLES(PORC), .STARTUP_CYCLES(SUC)) i_cfgseq_top (
        .clk(clk), .rst(rst), .power_ok(power_ok), .prog_n(prog_n), .clr_n(clr_n),
        .mode_sel(mode_sel), .load_done(load_done), .done(done), .busy_hi(busy_hi),
        .busy_lo_n(busy_lo_n), .io_tristate(io_tristate), .pulldn_en(pulldn_en),
        .mode_latched(mode_latched)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) begin
        bit nxt_runq;
        if (rst) begin
            m_st = 0; m_pc = 0; m_sc = 0; m_mode = '0; m_runq = 1'b0;
        end else begin
            nxt_runq = (m_st == 4);
            case (m_st)
                0: if (!power_ok) m_pc = 0;
                   else if (m_pc == PORC - 1) begin m_st = 1; m_pc = 0; end
                   else m_pc++;
                1: if (prog_n && clr_n) begin m_st = 2; m_mode = mode_sel; end
                2: if (!(prog_n && clr_n)) m_st = 1;
                   else if (load_done) begin m_st = 3; m_sc = 0; end
                3: if (!prog_n) m_st = 1;
                   else if (m_sc == SUC - 1) m_st = 4;
                   else m_sc++;
                4: if (!prog_n) m_st = 1;
                default: m_st = 0;
            endcase
            m_runq = nxt_runq;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            check(done == (m_st >= 3), "R5", "done", done, m_st >= 3);
            check(busy_hi == (m_st == 1 || m_st == 2), "R6", "busy_hi", busy_hi, m_st == 1 || m_st == 2);
            check(busy_lo_n == !(m_st == 1 || m_st == 2), "R6", "busy_lo_n", busy_lo_n, !(m_st == 1 || m_st == 2));
            check(pulldn_en == (m_st <= 2), "R7", "pulldn_en", pulldn_en, m_st <= 2);
            check(io_tristate == !(m_st == 4 && m_runq), "R10", "io_tristate", io_tristate, !(m_st == 4 && m_runq));
            check(mode_latched == m_mode, "R11", "mode_latched", mode_latched, m_mode);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int k;
        step(3);
        // R1: reset state
        check(done == 0 && busy_hi == 0 && busy_lo_n == 1, "R1", "status in reset", {done, busy_hi, busy_lo_n}, 3'b001);
        check(io_tristate == 1 && pulldn_en == 1 && mode_latched == 0, "R1", "io in reset",
              {io_tristate, pulldn_en, mode_latched}, {2'b11, 3'b000});
        rst = 1'b0; prog_n = 1'b0;
        step(1);
        check(busy_hi == 0 && done == 0, "R1", "por after release", busy_hi, 0);

        // R2: power-on wait with a dropout
        power_ok = 1'b1; step(3);
        power_ok = 1'b0; step(1);
        check(busy_hi == 0, "R2", "still in por after dropout", busy_hi, 0);
        power_ok = 1'b1;
        k = 0;
        while (busy_hi == 0 && k < 50) begin step(1); k++; end
        check(k == PORC, "R2", "cycles to init", k, PORC);

        // R3: pins must both be released
        mode_sel = 3'd5; step(4);
        check(mode_latched == 0 && busy_hi == 1, "R3", "held by prog_n", mode_latched, 0);
        prog_n = 1'b1; clr_n = 1'b0; step(3);
        check(mode_latched == 0, "R3", "held by clr_n", mode_latched, 0);
        clr_n = 1'b1; step(1);
        check(mode_latched == 5, "R3", "config entered, mode taken", mode_latched, 5);
        mode_sel = 3'd2; step(3);
        check(mode_latched == 5, "R11", "mode held in config", mode_latched, 5);

        // R4: abort by clr_n beats load_done
        clr_n = 1'b0; load_done = 1'b1; mode_sel = 3'd6; step(1);
        check(done == 0 && busy_hi == 1, "R4", "abort over load_done", done, 0);
        clr_n = 1'b1; load_done = 1'b0; step(1);
        check(mode_latched == 6, "R4", "re-entry after clr abort", mode_latched, 6);
        prog_n = 1'b0; mode_sel = 3'd3; step(1);
        prog_n = 1'b1; step(1);
        check(mode_latched == 3, "R4", "re-entry after prog abort", mode_latched, 3);

        // R8/R10: start-up length and release
        load_done = 1'b1; step(1);
        load_done = 1'b0;
        check(done == 1, "R4", "load_done enters startup", done, 1);
        k = 0;
        while (io_tristate == 1 && k < 50) begin k++; step(1); end
        check(k == SUC + 1, "R8", "tristate cycles after done", k, SUC + 1);

        // R9: clr_n ignored while operating
        clr_n = 1'b0; step(5);
        check(done == 1 && io_tristate == 0, "R9", "clr_n ignored in run", {done, io_tristate}, 2'b10);
        clr_n = 1'b1;

        // R9: program pulse reconfigures
        prog_n = 1'b0; mode_sel = 3'd7; step(1);
        check(done == 0 && busy_hi == 1 && io_tristate == 1 && pulldn_en == 1, "R9", "prog_n reconfig",
              {done, busy_hi, io_tristate, pulldn_en}, 4'b0111);
        prog_n = 1'b1; step(1);
        check(mode_latched == 7, "R11", "new mode latched", mode_latched, 7);
        load_done = 1'b1; step(1);
        load_done = 1'b0; clr_n = 1'b0; step(2);
        check(done == 1, "R9", "clr_n ignored in startup", done, 1);
        clr_n = 1'b1; step(6);
        check(io_tristate == 0, "R10", "released again", io_tristate, 0);

        // R9: program during start-up
        prog_n = 1'b0; step(1);
        prog_n = 1'b1; step(1);
        load_done = 1'b1; step(1);
        load_done = 1'b0; step(1);
        prog_n = 1'b0; step(1);
        check(done == 0 && busy_hi == 1, "R9", "prog_n in startup", done, 0);
        prog_n = 1'b1; step(4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule